// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table in memory. A request carries the virtual address, the kind of access (fetch, load or store), the current privilege (supervisor or user) and two permission modifiers. The first modifier lets supervisor loads and stores reach user pages. The second lets loads read execute-only pages. The block answers with either a physical address or a fault and its cause code. The fault value reported is always the original virtual address.

A translation-control register turns translation on or off and holds the page number of the root table. When translation is off, the virtual address passes straight through, one cycle after the request is accepted, and no memory access is made. When it is on, the block reads at most two entries through a simple request/acknowledge memory port. It checks the final entry's type, permissions, privilege, alignment and page-number range. When an access succeeds, it sets the entry's accessed flag, and for a store also its dirty flag. It writes the entry back only when one of those flags actually changes.

The block handles one request at a time. It accepts a new request only when idle and gives a single-cycle response pulse.

Top module: `vm_translator`

## Requirements
- R1: Writing the control register with bit 31 set stores bit 31, zeroes bits 30:22 and keeps bits 21:0 as the root page number. Writing it with bit 31 clear stores zero. The register reads back what was stored, and reads zero after reset.
- R2: With control bit 31 clear, the response comes in the cycle after acceptance. It carries no fault and a physical address equal to the zero-extended virtual address, and no memory access is made.
- R3: The first entry is read at root_ppn*4096 + VA[31:22]*4. When that entry is a pointer, the second entry is read at entry_ppn*4096 + VA[21:12]*4, where entry_ppn is entry bits 31:10.
- R4: Entry bits 3:0 are read as {X,W,R,V}. Code 0001 is a pointer. Codes 0011, 0111, 1001, 1011 and 1111 are leaves. Every other code, including 0101 and 1101, gives a page fault.
- R5: A first-level leaf whose page-number bits 9:0 are nonzero gives a page fault. An aligned first-level leaf maps to {ppn[21:10], VA[21:12], VA[11:0]}. A second-level leaf maps to {ppn, VA[11:0]}.
- R6: A second-level entry with code 0001 gives a page fault.
- R7: A leaf whose page number has any bit at position 20 or above set gives a page fault.
- R8: Access kind is encoded 0 fetch, 1 load, 2 store. A fetch needs X. A load needs R, or X when the execute-readable modifier is set. A store needs W. A missing permission gives a page fault.
- R9: Entry bit 4 (user page) must be 0 in supervisor mode and 1 in user mode, or a page fault follows. For loads and stores in supervisor mode with the user-access modifier set, this check is skipped.
- R10: A successful translation sets bit 6 of the entry, and a store also sets bit 7. The new value is written to the address the entry was read from, and only if it differs from the value read.
- R11: An error on a table read gives an access fault. On every fault, resp_tval carries the request's virtual address.
- R12: The cause codes are: fetch access 1, load access 5, store access 7, fetch page 12, load page 13, store page 15.
- R13: req_ready is high only when idle, and low while a table access is in flight. resp_valid is a single-cycle pulse. The memory request holds its address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the translation-control register |
| ctl_wdata | input | 32 | Value to write to the control register |
| ctl_rdata | output | 32 | Current control register value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_smode | input | 1 | 1 for supervisor, 0 for user |
| req_sum | input | 1 | Supervisor may reach user pages for loads and stores |
| req_mxr | input | 1 | Loads may read execute-only pages |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 4 | Fault cause code |
| resp_paddr | output | 34 | Physical address |
| resp_tval | output | 32 | Virtual address of the request |
| mem_req | output | 1 | Table memory access request |
| mem_we | output | 1 | Access is an entry write-back |
| mem_addr | output | 34 | Physical byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed |

## Verification
The bench builds the block with its default page-number limit of 20 bits. This keeps the whole leaf decision within one sweep: all 16 type codes, both values of the user bit, all three access kinds, both privilege levels and both modifiers, checked against an arithmetic model of permission and privilege. That sweep also confirms the first-level address, the superpage address composition and the flag write-back. Directed walks cover second-level pointers, the page-number limit, misaligned superpages, read errors at either level, pass-through and the write-back skipped when the flags are already set.

// File: rtl/vm_pkg.sv
package vm_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int PPN_W   = 22;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int PTE_W   = 32;
    localparam int CAUSE_W = 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        EV_PTR,
        EV_LEAF,
        EV_FAULT
    } eval_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LVL1,
        ST_LVL2,
        ST_WBACK,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rsw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;

    function automatic logic [CAUSE_W-1:0] fault_cause(acc_e kind, logic page);
        logic [CAUSE_W-1:0] c;
        case (kind)
            ACC_FETCH: c = page ? 4'd12 : 4'd1;
            ACC_LOAD:  c = page ? 4'd13 : 4'd5;
            default:   c = page ? 4'd15 : 4'd7;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vm_root_reg.sv
module vm_root_reg
    import vm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             enabled,
    output logic [PPN_W-1:0] root_ppn
);
    logic [31:0] q;
    logic        unused_asid;

    assign unused_asid = ^wdata[30:PPN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            if (wdata[31]) q <= {1'b1, {(31-PPN_W){1'b0}}, wdata[PPN_W-1:0]};
            else           q <= '0;
        end
    end

    assign rdata    = q;
    assign enabled  = q[31];
    assign root_ppn = q[PPN_W-1:0];
endmodule

// File: rtl/vm_pte_eval.sv
module vm_pte_eval
    import vm_pkg::*;
#(
    parameter int PPN_OK_W = 20
) (
    input  pte_t             pte,
    input  logic             first_lvl,
    input  acc_e             kind,
    input  logic             smode,
    input  logic             sum,
    input  logic             mxr,
    input  logic [IDX_W-1:0] va_idx_lo,
    output eval_e            verdict,
    output logic [PPN_W-1:0] ppn_out,
    output logic [PTE_W-1:0] pte_upd,
    output logic             upd_needed
);
    logic is_ptr, is_leaf, misalign, too_big, perm_ok, user_ok;
    pte_t upd;

    always_comb begin
        is_ptr   = pte.v && !pte.r && !pte.w && !pte.x;
        is_leaf  = pte.v && (pte.r || pte.x) && !(pte.w && !pte.r);
        misalign = first_lvl && (pte.ppn[IDX_W-1:0] != '0);
        too_big  = (pte.ppn >> PPN_OK_W) != '0;

        case (kind)
            ACC_FETCH: perm_ok = pte.x;
            ACC_LOAD:  perm_ok = pte.r || (mxr && pte.x);
            default:   perm_ok = pte.w;
        endcase

        user_ok = ((kind != ACC_FETCH) && smode && sum) || (pte.u != smode);

        ppn_out = first_lvl ? {pte.ppn[PPN_W-1:IDX_W], va_idx_lo} : pte.ppn;

        upd   = pte;
        upd.a = 1'b1;
        if (kind == ACC_STORE) upd.d = 1'b1;
        pte_upd    = upd;
        upd_needed = (upd != pte);

        if (is_ptr && first_lvl)
            verdict = EV_PTR;
        else if (is_leaf && !misalign && !too_big && perm_ok && user_ok)
            verdict = EV_LEAF;
        else
            verdict = EV_FAULT;
    end
endmodule

// File: rtl/vm_translator.sv
module vm_translator
    import vm_pkg::*;
#(
    parameter int PPN_OK_W = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [31:0]          ctl_wdata,
    output logic [31:0]          ctl_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [1:0]           req_kind,
    input  logic                 req_smode,
    input  logic                 req_sum,
    input  logic                 req_mxr,
    output logic                 resp_valid,
    output logic                 resp_fault,
    output logic [CAUSE_W-1:0]   resp_cause,
    output logic [PA_W-1:0]      resp_paddr,
    output logic [VA_W-1:0]      resp_tval,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [PA_W-1:0]      mem_addr,
    output logic [PTE_W-1:0]     mem_wdata,
    input  logic [PTE_W-1:0]     mem_rdata,
    input  logic                 mem_ack,
    input  logic                 mem_err
);
    localparam int IDX1_LO = OFF_W + IDX_W;

    st_e              st;
    logic [VA_W-1:0]  va_q;
    acc_e             kind_q;
    logic             smode_q, sum_q, mxr_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [PA_W-1:0]  wb_addr_q;
    logic [PTE_W-1:0] wb_data_q;
    logic             fault_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [PA_W-1:0]  paddr_q;

    logic             tr_on;
    logic [PPN_W-1:0] root_ppn;

    eval_e            verdict;
    logic [PPN_W-1:0] leaf_ppn;
    logic [PTE_W-1:0] pte_upd;
    logic             upd_needed;
    logic [IDX_W-1:0] cur_idx;
    pte_t             pte_in;

    vm_root_reg u_root (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .rdata    (ctl_rdata),
        .enabled  (tr_on),
        .root_ppn (root_ppn)
    );

    assign pte_in  = pte_t'(mem_rdata);
    assign cur_idx = (st == ST_LVL1) ? va_q[VA_W-1:IDX1_LO] : va_q[IDX1_LO-1:OFF_W];

    vm_pte_eval #(.PPN_OK_W(PPN_OK_W)) u_eval (
        .pte        (pte_in),
        .first_lvl  (st == ST_LVL1),
        .kind       (kind_q),
        .smode      (smode_q),
        .sum        (sum_q),
        .mxr        (mxr_q),
        .va_idx_lo  (va_q[IDX1_LO-1:OFF_W]),
        .verdict    (verdict),
        .ppn_out    (leaf_ppn),
        .pte_upd    (pte_upd),
        .upd_needed (upd_needed)
    );

    always_comb begin
        mem_req   = (st == ST_LVL1) || (st == ST_LVL2) || (st == ST_WBACK);
        mem_we    = (st == ST_WBACK);
        mem_wdata = wb_data_q;
        if (st == ST_WBACK) mem_addr = wb_addr_q;
        else                mem_addr = {tbl_ppn_q, cur_idx, 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            kind_q    <= ACC_FETCH;
            smode_q   <= 1'b0;
            sum_q     <= 1'b0;
            mxr_q     <= 1'b0;
            tbl_ppn_q <= '0;
            wb_addr_q <= '0;
            wb_data_q <= '0;
            fault_q   <= 1'b0;
            cause_q   <= '0;
            paddr_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_vaddr;
                        kind_q    <= acc_e'(req_kind);
                        smode_q   <= req_smode;
                        sum_q     <= req_sum;
                        mxr_q     <= req_mxr;
                        tbl_ppn_q <= root_ppn;
                        fault_q   <= 1'b0;
                        cause_q   <= '0;
                        if (tr_on) begin
                            st <= ST_LVL1;
                        end else begin
                            paddr_q <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
                            st      <= ST_DONE;
                        end
                    end
                end
                ST_LVL1, ST_LVL2: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            fault_q <= 1'b1;
                            cause_q <= fault_cause(kind_q, 1'b0);
                            st      <= ST_DONE;
                        end else begin
                            case (verdict)
                                EV_PTR: begin
                                    tbl_ppn_q <= pte_in.ppn;
                                    st        <= ST_LVL2;
                                end
                                EV_LEAF: begin
                                    paddr_q <= {leaf_ppn, va_q[OFF_W-1:0]};
                                    if (upd_needed) begin
                                        wb_addr_q <= mem_addr;
                                        wb_data_q <= pte_upd;
                                        st        <= ST_WBACK;
                                    end else begin
                                        st <= ST_DONE;
                                    end
                                end
                                default: begin
                                    fault_q <= 1'b1;
                                    cause_q <= fault_cause(kind_q, 1'b1);
                                    st      <= ST_DONE;
                                end
                            endcase
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            fault_q <= 1'b1;
                            cause_q <= fault_cause(kind_q, 1'b0);
                        end
                        st <= ST_DONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign resp_valid = (st == ST_DONE);
    assign resp_fault = fault_q;
    assign resp_cause = cause_q;
    assign resp_paddr = paddr_q;
    assign resp_tval  = va_q;
endmodule

// File: rtl/vm_translator_chk.sv
module vm_translator_chk
    import vm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ctl_we,
    input logic [31:0]        ctl_wdata,
    input logic [31:0]        ctl_rdata,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               resp_valid,
    input logic               resp_fault,
    input logic [CAUSE_W-1:0] resp_cause,
    input logic [PA_W-1:0]    resp_paddr,
    input logic [VA_W-1:0]    resp_tval,
    input logic               mem_req,
    input logic               mem_we,
    input logic [PA_W-1:0]    mem_addr,
    input logic [PTE_W-1:0]   mem_wdata,
    input logic               mem_ack
);
    p_ctl_write_r1: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> ctl_rdata == ($past(ctl_wdata[31]) ?
                                 {1'b1, 9'b0, $past(ctl_wdata[21:0])} : 32'h0));

    p_bare_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !ctl_rdata[31]) |=>
        (resp_valid && !resp_fault && resp_paddr == {2'b00, $past(req_vaddr)}));

    p_page_offset_r5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> resp_paddr[OFF_W-1:0] == resp_tval[OFF_W-1:0]);

    p_wb_sets_a_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[6]);

    p_cause_set_r12: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |->
        (resp_cause == 4'd1 || resp_cause == 4'd5 || resp_cause == 4'd7 ||
         resp_cause == 4'd12 || resp_cause == 4'd13 || resp_cause == 4'd15));

    p_busy_not_ready_r13: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    p_resp_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    p_mem_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind vm_translator vm_translator_chk u_chk (.*);

// File: tb/tb_vm_translator.sv
module tb_vm_translator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_smode = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
    logic        resp_valid, resp_fault;
    logic [3:0]  resp_cause;
    logic [33:0] resp_paddr;
    logic [31:0] resp_tval;
    logic        mem_req, mem_we;
    logic [33:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [33:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] pmem [logic [33:0]];

    always #10 clk = ~clk;

    vm_translator dut (.*);

    always @(negedge clk) begin
        if (mem_req) begin
            mem_ack   = 1'b1;
            mem_err   = (mem_addr[33:32] != 2'b00);
            mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
            if (mem_we) begin
                wr_cnt++;
                wr_addr = mem_addr;
                wr_data = mem_wdata;
            end else begin
                rd_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input logic [1:0] kind, input logic sm, su, mx,
                         output logic flt, output logic [3:0] cs, output logic [33:0] pa,
                         output logic [31:0] tv, output int lat, output logic rdy1, output logic pulse_ok);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        req_smode = sm; req_sum = su; req_mxr = mx;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rdy1 = req_ready;
        lat = 1;
        while (!resp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        flt = resp_fault; cs = resp_cause; pa = resp_paddr; tv = resp_tval;
        @(negedge clk);
        pulse_ok = !resp_valid;
    endtask

    function automatic logic [3:0] pcause(input logic [1:0] k);
        return (k == 2'd0) ? 4'd12 : (k == 2'd1) ? 4'd13 : 4'd15;
    endfunction
    function automatic logic [3:0] acause(input logic [1:0] k);
        return (k == 2'd0) ? 4'd1 : (k == 2'd1) ? 4'd5 : 4'd7;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic flt, rdy1, pok;
        logic [3:0] cs;
        logic [33:0] pa;
        logic [31:0] tv, pte, va;
        int lat, rd0, wr0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ctl_rdata == 32'h0, "R1 reset ctl", ctl_rdata, 0);
        chk(req_ready && !resp_valid && !mem_req, "R13 reset idle",
            {req_ready, resp_valid, mem_req}, 3'b100);

        // R1: ASID bits dropped, bit 31 clear stores zero
        ctl_write(32'hFFC0_0001);
        chk(ctl_rdata == 32'h8000_0001, "R1 asid zeroed", ctl_rdata, 32'h8000_0001);
        ctl_write(32'h0000_1234);
        chk(ctl_rdata == 32'h0, "R1 off reads zero", ctl_rdata, 0);

        // R2: pass-through
        rd0 = rd_cnt;
        xlate(32'hDEAD_BEEC, 2'd1, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(!flt && pa == 34'h0_DEAD_BEEC, "R2 bare paddr", pa, 34'h0_DEAD_BEEC);
        chk(lat == 1, "R2 bare latency", lat, 1);
        chk(rd_cnt == rd0, "R2 bare no memory", rd_cnt - rd0, 0);
        chk(pok, "R13 pulse", 0, 1);

        // Sweep of first-level leaves: every code, user bit, kind, mode, modifier
        ctl_write(32'h8000_0001);
        va = 32'h0045_6123;
        for (int c = 0; c < 16; c++) begin
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 3; k++) begin
                    for (int m = 0; m < 8; m++) begin
                        logic sm, su, mx, leaf, perm, uok, ok;
                        logic [3:0] cd;
                        sm = m[0]; su = m[1]; mx = m[2];
                        cd = 4'(c);
                        pte = {22'h000400, 2'b00, 2'b00, 1'b0, 1'(u), cd};
                        pmem.delete();
                        pmem[34'h1004] = pte;
                        leaf = (cd == 4'b0011) || (cd == 4'b0111) || (cd == 4'b1001) ||
                               (cd == 4'b1011) || (cd == 4'b1111);
                        perm = (k == 0) ? cd[3] : (k == 1) ? (cd[1] | (mx & cd[3])) : cd[2];
                        uok  = ((k != 0) && sm && su) || (1'(u) != sm);
                        ok   = leaf && perm && uok;
                        wr0  = wr_cnt;
                        xlate(va, 2'(k), sm, su, mx, flt, cs, pa, tv, lat, rdy1, pok);
                        chk(flt == !ok, "R4 R8 R9 fault decision", flt, !ok);
                        chk(!rdy1, "R13 busy not ready", rdy1, 0);
                        if (ok) begin
                            chk(pa == 34'h0_0045_6123, "R5 superpage paddr", pa, 34'h0_0045_6123);
                            chk(wr_cnt == wr0 + 1 && wr_addr == 34'h1004 &&
                                wr_data == (pte | 32'h40 | ((k == 2) ? 32'h80 : 32'h0)),
                                "R10 R3 flag write-back", wr_data,
                                pte | 32'h40 | ((k == 2) ? 32'h80 : 32'h0));
                        end else begin
                            chk(cs == pcause(2'(k)), "R12 page cause", cs, pcause(2'(k)));
                            chk(wr_cnt == wr0, "R10 no write on fault", wr_cnt - wr0, 0);
                            chk(tv == va, "R11 tval", tv, va);
                        end
                    end
                end
            end
        end

        // Second-level walk
        va = 32'h0080_5ABC;
        pmem.delete();
        pmem[34'h1008] = {22'h000002, 10'h001};
        pmem[34'h2014] = {22'h000123, 10'h043};   // A set, R,V, supervisor page
        wr0 = wr_cnt;
        xlate(va, 2'd1, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(!flt && pa == 34'h0_0012_3ABC, "R3 R5 second-level paddr", pa, 34'h0_0012_3ABC);
        chk(wr_cnt == wr0, "R10 unchanged entry not written", wr_cnt - wr0, 0);
        chk(lat == 3, "R3 two reads latency", lat, 3);

        pmem[34'h2014] = {22'h000123, 10'h047};   // A set, W,R,V, D clear
        wr0 = wr_cnt;
        xlate(va, 2'd2, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(!flt && wr_cnt == wr0 + 1 && wr_addr == 34'h2014 && wr_data == 32'h0004_8CC7,
            "R10 store sets D", wr_data, 32'h0004_8CC7);

        pmem[34'h2014] = {22'h000123, 10'h0C7};   // A and D already set
        wr0 = wr_cnt;
        xlate(va, 2'd2, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(!flt && wr_cnt == wr0, "R10 no write when flags set", wr_cnt - wr0, 0);

        pmem[34'h2014] = {22'h000123, 10'h001};   // pointer at second level
        xlate(va, 2'd1, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(flt && cs == 4'd13, "R6 second-level pointer", {flt, cs}, {1'b1, 4'd13});

        pmem[34'h2014] = {22'h100123, 10'h047};   // page number beyond limit
        xlate(va, 2'd2, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(flt && cs == 4'd15, "R7 page number too wide", {flt, cs}, {1'b1, 4'd15});

        // Misaligned superpage
        pmem.delete();
        pmem[34'h1004] = {22'h000401, 10'h049};
        xlate(32'h0045_6000, 2'd0, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(flt && cs == 4'd12, "R5 misaligned superpage", {flt, cs}, {1'b1, 4'd12});

        // Error on the second-level read
        pmem[34'h1004] = {22'h100000, 10'h001};
        xlate(32'h0045_6000, 2'd1, 1'b1, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
        chk(flt && cs == 4'd5, "R11 second-level read error", {flt, cs}, {1'b1, 4'd5});

        // Error on the first-level read, every kind
        ctl_write(32'h803F_FFFF);
        for (int k = 0; k < 3; k++) begin
            xlate(32'h1234_5678, 2'(k), 1'b0, 1'b0, 1'b0, flt, cs, pa, tv, lat, rdy1, pok);
            chk(flt && cs == acause(2'(k)), "R11 R12 access cause", cs, acause(2'(k)));
            chk(tv == 32'h1234_5678, "R11 tval on access fault", tv, 32'h1234_5678);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule